// File: doc/BRIEF.md
# Beam Dump Request Matrix

This block gathers the OK levels of up to 96 circuit interlock channels, arranged as panels of 16, and turns them into two beam-dump requests. One request is driven only by channels classed as essential, and no mask can silence it. The other request covers every channel: essential channels always count, while auxiliary channels count unless their mask bit is set. Both requests come from a short, registered hardware path that does not wait on any controller scan cycle.

Each channel carries three configuration bits: whether it is in use, whether it is essential, and whether it is masked. A single write port sets them one channel at a time. A channel that is not in use is treated as OK no matter what its input does. The block also exposes a per-channel fault vector, registered alongside the requests, so that the state of every input can be seen. After reset the configuration is empty and both requests sit asserted until the first clock in which nothing faults.

Top module: `dump_matrix`

## Requirements
- R1: While reset is held, both dump requests are 1 and every bit of `fault_status` is 0; reset clears every channel's configuration to not-in-use, so one clock after the synchronised reset release, both requests drop to 0.
- R2: A channel whose in-use bit is 0 never raises a request or its `fault_status` bit, whatever its `chan_ok` level.
- R3: An in-use essential channel whose `chan_ok` is 0 drives both `dump_req_ess` and `dump_req_all` to 1 at the first rising edge after the input falls.
- R4: The mask bit of an essential channel has no effect: a masked essential channel whose input is 0 still asserts both requests.
- R5: An in-use, unmasked auxiliary channel (essential bit 0) whose input is 0 asserts `dump_req_all` and leaves `dump_req_ess` at 0.
- R6: An in-use, masked auxiliary channel whose input is 0 asserts neither request.
- R7: A request stays at 1 while any contributing channel is still not OK, and returns to 0 at the first rising edge after every contributing channel is OK again.
- R8: Bit i of `fault_status` is the registered value of (channel i in use AND `chan_ok[i]` = 0), with one clock of latency, whatever the channel's class or mask.
- R9: A configuration write with `cfg_ch` of 96 or above changes no channel's configuration.
- R10: Channel index i maps to bit i of `chan_ok` and of `fault_status` for every i from 0 to 95, across all six panels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| chan_ok | input | 96 | Per-channel OK level, 1 = healthy |
| cfg_we | input | 1 | Configuration write strobe for one channel |
| cfg_ch | input | 7 | Channel index written when `cfg_we` is 1 |
| cfg_used | input | 1 | New in-use bit for the addressed channel |
| cfg_essential | input | 1 | New class bit, 1 = essential, 0 = auxiliary |
| cfg_mask | input | 1 | New mask bit, 1 = masked (auxiliary only) |
| dump_req_ess | output | 1 | Registered unmaskable request from essential channels |
| dump_req_all | output | 1 | Registered request from essential and unmasked auxiliary channels |
| fault_status | output | 96 | Registered per-channel fault flags |

## Verification
The bench targets the points where the class and mask bits interact: a masked essential channel must still dump on both outputs, while a masked auxiliary channel must raise only its status bit. A design that let the mask reach essential channels would drop both requests, and one that took status after the mask would hide that fault. It checks that unused channels held low stay silent, that out-of-range writes leave every channel untouched, and that a request holds while one of two faults remains. A sweep over all 96 channels catches a panel slice that is wired to the wrong offset.

// File: rtl/dump_matrix_pkg.sv
package dump_matrix_pkg;

  typedef struct packed {
    logic used;
    logic essential;
    logic masked;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_IDLE = '{used: 1'b0, essential: 1'b0, masked: 1'b0};

endpackage

// File: rtl/dump_cfg_store.sv
module dump_cfg_store
  import dump_matrix_pkg::*;
#(
  parameter int N_CH = 96,
  parameter int CH_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic                  cfg_used,
  input  logic                  cfg_essential,
  input  logic                  cfg_mask,
  output chan_cfg_t [N_CH-1:0]  cfg_q
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  chan_cfg_t [N_CH-1:0] cfg_d;
  logic                 addr_ok;

  assign addr_ok = (cfg_ch <= LAST_CH);

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_ok && (cfg_ch == CH_W'(i))) begin
        cfg_d[i].used      = cfg_used;
        cfg_d[i].essential = cfg_essential;
        cfg_d[i].masked    = cfg_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= {N_CH{CFG_IDLE}};
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  // R9: an out-of-range write leaves the table untouched
  p_bad_addr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !addr_ok) |=> $stable(cfg_q));

endmodule

// File: rtl/dump_panel.sv
module dump_panel
  import dump_matrix_pkg::*;
#(
  parameter int PANEL_W = 16
) (
  input  logic                     [PANEL_W-1:0] ok,
  input  chan_cfg_t                [PANEL_W-1:0] cfg,
  output logic                     [PANEL_W-1:0] fault,
  output logic                                   ess_hit,
  output logic                                   aux_hit
);

  logic [PANEL_W-1:0] ess_vec;
  logic [PANEL_W-1:0] aux_vec;

  always_comb begin
    for (int i = 0; i < PANEL_W; i++) begin
      fault[i]   = cfg[i].used & ~ok[i];
      ess_vec[i] = fault[i] & cfg[i].essential;
      aux_vec[i] = fault[i] & ~cfg[i].essential & ~cfg[i].masked;
    end
    ess_hit = |ess_vec;
    aux_hit = |aux_vec;
  end

endmodule

// File: rtl/dump_matrix.sv
module dump_matrix
  import dump_matrix_pkg::*;
#(
  parameter int N_PANELS = 6,
  parameter int PANEL_W  = 16,
  parameter int N_CH     = N_PANELS * PANEL_W,
  parameter int CH_W     = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   chan_ok,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic              cfg_used,
  input  logic              cfg_essential,
  input  logic              cfg_mask,
  output logic              dump_req_ess,
  output logic              dump_req_all,
  output logic [N_CH-1:0]   fault_status
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  chan_cfg_t [N_CH-1:0]     cfg_q;
  logic [N_CH-1:0]          fault_d;
  logic [N_PANELS-1:0]      panel_ess;
  logic [N_PANELS-1:0]      panel_aux;
  logic                     ess_any;
  logic                     all_any;

  dump_cfg_store #(.N_CH(N_CH), .CH_W(CH_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cfg_we        (cfg_we),
    .cfg_ch        (cfg_ch),
    .cfg_used      (cfg_used),
    .cfg_essential (cfg_essential),
    .cfg_mask      (cfg_mask),
    .cfg_q         (cfg_q)
  );

  for (genvar p = 0; p < N_PANELS; p++) begin : g_panel
    dump_panel #(.PANEL_W(PANEL_W)) u_panel (
      .ok      (chan_ok[p*PANEL_W +: PANEL_W]),
      .cfg     (cfg_q[p*PANEL_W +: PANEL_W]),
      .fault   (fault_d[p*PANEL_W +: PANEL_W]),
      .ess_hit (panel_ess[p]),
      .aux_hit (panel_aux[p])
    );
  end

  // next-state
  logic ess_d;
  logic all_d;
  always_comb begin
    ess_any = |panel_ess;
    all_any = ess_any | (|panel_aux);
    ess_d   = ess_any;
    all_d   = all_any;
  end

  // registers; reset leaves both requests asserted (fail-safe)
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dump_req_ess <= 1'b1;
      dump_req_all <= 1'b1;
      fault_status <= '0;
    end else begin
      dump_req_ess <= ess_d;
      dump_req_all <= all_d;
      fault_status <= fault_d;
    end
  end

  // R3/R4: the unmaskable request never stands alone
  p_ess_implies_all_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dump_req_ess |-> dump_req_all);

  // R3: an essential fault reaches the output one clock later
  p_ess_latency_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ess_any |=> (dump_req_ess && dump_req_all));

  // R7: a clean cycle clears both requests on the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !all_any |=> (!dump_req_ess && !dump_req_all));

  // R5: auxiliary-only fault raises only the combined request
  p_aux_only_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (all_any && !ess_any) |=> (dump_req_all && !dump_req_ess));

endmodule

// File: tb/dump_matrix_test.sv
`timescale 1ns/1ps
module dump_matrix_test;

  localparam int N_CH = 96;
  localparam int CH_W = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_CH-1:0]   chan_ok;
  logic              cfg_we;
  logic [CH_W-1:0]   cfg_ch;
  logic              cfg_used, cfg_essential, cfg_mask;
  logic              dump_req_ess, dump_req_all;
  logic [N_CH-1:0]   fault_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dump_matrix uut (
    .clk(clk), .rst_n(rst_n), .chan_ok(chan_ok),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_used(cfg_used),
    .cfg_essential(cfg_essential), .cfg_mask(cfg_mask),
    .dump_req_ess(dump_req_ess), .dump_req_all(dump_req_all),
    .fault_status(fault_status)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [N_CH-1:0] act, logic [N_CH-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int ch, logic u, logic e, logic m);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch);
    cfg_used = u; cfg_essential = e; cfg_mask = m;
    step();
    cfg_we = 1'b0;
  endtask

  function automatic logic [N_CH-1:0] bit_at(int i);
    logic [N_CH-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 dump_req_ess in reset", dump_req_ess, 1'b1);
    chk("R1 dump_req_all in reset", dump_req_all, 1'b1);
    chk_vec("R1 status in reset", fault_status, '0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 dump_req_ess after release", dump_req_ess, 1'b0);
    chk("R1 dump_req_all after release", dump_req_all, 1'b0);
  endtask

  task automatic t_unused();
    chan_ok = '0;
    step();
    chk("R2 unused ess", dump_req_ess, 1'b0);
    chk("R2 unused all", dump_req_all, 1'b0);
    chk_vec("R2 unused status", fault_status, '0);
    chan_ok = '1;
    step();
  endtask

  task automatic t_essential();
    write_cfg(5, 1'b1, 1'b1, 1'b0);
    chan_ok[5] = 1'b0;
    step();
    chk("R3 essential ess", dump_req_ess, 1'b1);
    chk("R3 essential all", dump_req_all, 1'b1);
    chk_vec("R8 essential status", fault_status, bit_at(5));
    chan_ok[5] = 1'b1;
    step();
    chk("R7 essential cleared ess", dump_req_ess, 1'b0);
    chk("R7 essential cleared all", dump_req_all, 1'b0);
  endtask

  task automatic t_ess_masked();
    write_cfg(20, 1'b1, 1'b1, 1'b1);
    chan_ok[20] = 1'b0;
    step();
    chk("R4 masked essential ess", dump_req_ess, 1'b1);
    chk("R4 masked essential all", dump_req_all, 1'b1);
    chan_ok[20] = 1'b1;
    step();
  endtask

  task automatic t_aux();
    write_cfg(40, 1'b1, 1'b0, 1'b0);
    chan_ok[40] = 1'b0;
    step();
    chk("R5 aux ess stays low", dump_req_ess, 1'b0);
    chk("R5 aux all", dump_req_all, 1'b1);
    chk_vec("R8 aux status", fault_status, bit_at(40));
    chan_ok[40] = 1'b1;
    step();
  endtask

  task automatic t_aux_masked();
    write_cfg(41, 1'b1, 1'b0, 1'b1);
    chan_ok[41] = 1'b0;
    step();
    chk("R6 masked aux ess", dump_req_ess, 1'b0);
    chk("R6 masked aux all", dump_req_all, 1'b0);
    chk_vec("R8 masked aux status", fault_status, bit_at(41));
    chan_ok[41] = 1'b1;
    step();
  endtask

  task automatic t_hold();
    chan_ok[5]  = 1'b0;
    chan_ok[40] = 1'b0;
    step();
    chk("R7 two faults all", dump_req_all, 1'b1);
    chan_ok[5] = 1'b1;
    step();
    chk("R7 aux still holds all", dump_req_all, 1'b1);
    chk("R7 ess released", dump_req_ess, 1'b0);
    repeat (2) step();
    chk("R7 held while fault stays", dump_req_all, 1'b1);
    chan_ok[40] = 1'b1;
    step();
    chk("R7 all released", dump_req_all, 1'b0);
  endtask

  task automatic t_bad_addr();
    write_cfg(5,  1'b0, 1'b0, 1'b0);
    write_cfg(20, 1'b0, 1'b0, 1'b0);
    write_cfg(40, 1'b0, 1'b0, 1'b0);
    write_cfg(41, 1'b0, 1'b0, 1'b0);
    write_cfg(96,  1'b1, 1'b1, 1'b0);
    write_cfg(127, 1'b1, 1'b1, 1'b0);
    write_cfg(100, 1'b1, 1'b1, 1'b0);
    chan_ok = '0;
    step();
    chk("R9 bad address ess", dump_req_ess, 1'b0);
    chk("R9 bad address all", dump_req_all, 1'b0);
    chk_vec("R9 bad address status", fault_status, '0);
    chan_ok = '1;
    step();
  endtask

  task automatic t_sweep();
    for (int i = 0; i < N_CH; i++) begin
      write_cfg(i, 1'b1, 1'b1, 1'b0);
      chan_ok[i] = 1'b0;
      step();
      chk($sformatf("R10 channel %0d ess", i), dump_req_ess, 1'b1);
      chk_vec($sformatf("R10 channel %0d status", i), fault_status, bit_at(i));
      chan_ok[i] = 1'b1;
      write_cfg(i, 1'b0, 1'b0, 1'b0);
    end
    step();
    chk("R10 sweep end clear", dump_req_all, 1'b0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1..R10 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    chan_ok = '1;
    cfg_we = 1'b0; cfg_ch = '0;
    cfg_used = 1'b0; cfg_essential = 1'b0; cfg_mask = 1'b0;
    @(negedge clk);
    t_reset();
    t_unused();
    t_essential();
    t_ess_masked();
    t_aux();
    t_aux_masked();
    t_hold();
    t_bad_addr();
    t_sweep();
    finish_run();
  end

endmodule